// File: doc/BRIEF.md
# Trigger Event Queue Controller

This block arbitrates event requests for a data acquisition system and turns them into a single ordered stream of messages for the link fanout. Requests come in two classes. A trigger request is never stored. It becomes a message on the next cycle if the controller is idle, and it is counted as skipped if the controller is busy. Requests from calibration or utility generators are written into a small queue and are issued one by one, in arrival order.

Each issued message carries a command code, a flag that marks trigger messages, and an event number. The event number advances only when the fanout accepts a message. After a message is accepted, the controller stays busy, which covers the time the digitizers are occupied. The busy window ends when the fanout reports done or when a programmable timeout expires. Two saturating counters record skipped triggers and queue requests dropped because the queue was full. The skip count gives an estimate of dead time.

Top module: `evq_ctrl`

## Requirements
- R1: After reset, msg_valid and busy are 0, msg_evnum is 0, and skip_cnt and drop_cnt are 0.
- R2: A trigger request that arrives while busy is 0 shows up as msg_valid=1 with msg_trig=1 and msg_cmd equal to the trigger's code in the cycle after the request.
- R3: A trigger request that arrives while busy is 1 issues no message, leaves msg_evnum unchanged and adds one to skip_cnt. skip_cnt saturates at 2^CNT_W-1.
- R4: Queued requests are issued with msg_trig=0, one message per busy window, in the order they arrived.
- R5: The queue holds DEPTH (16) entries. A queue request that arrives while 16 entries are held is discarded and adds one to drop_cnt. drop_cnt saturates at 2^CNT_W-1.
- R6: When a trigger request arrives while busy is 0 and the queue is not empty, the trigger is issued first. The queued entry stays in the queue and is issued afterwards.
- R7: While msg_valid=1 and msg_ready=0, msg_cmd, msg_trig and msg_evnum hold their values. msg_evnum starts at 0 and increases by one at each accepted message (msg_valid and msg_ready both 1), and at no other time.
- R8: From the cycle after an accepted message, busy stays 1 and msg_valid stays 0 until done is sampled 1. busy is 0 in the cycle after that.
- R9: If done never comes, busy lasts exactly max(timeout,1) cycles after the accepting edge.
- R10: A trigger request and a queue request in the same idle cycle: the trigger is issued, and the queue request is stored and issued later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_req | input | 1 | Trigger request pulse |
| trig_cmd | input | CMD_W | Command code of the trigger request |
| q_req | input | 1 | Queueable request pulse |
| q_cmd | input | CMD_W | Command code of the queueable request |
| timeout | input | TO_W | Busy window limit in cycles (0 acts as 1) |
| done | input | 1 | Fanout reports that the digitizers are finished |
| msg_ready | input | 1 | Fanout accepts the presented message |
| msg_valid | output | 1 | A message is presented |
| msg_cmd | output | CMD_W | Command code of the message |
| msg_trig | output | 1 | 1 if the message came from a trigger |
| msg_evnum | output | EVN_W | Event number of the message |
| busy | output | 1 | A message is pending or its busy window is open |
| skip_cnt | output | CNT_W | Saturating count of skipped triggers |
| drop_cnt | output | CNT_W | Saturating count of dropped queue requests |

## Verification
Two functions can fall into the same idle cycle:
- Serving a trigger at once.
- Popping the next queued entry.

The bench provokes this by storing an entry during a busy window. It ends the window with done and then raises a trigger in the first idle cycle, which is exactly when the queued entry becomes eligible. The result is judged at the ports: the trigger message must come out first and the skip count must not move. The queued code must come out afterwards. A second case raises a trigger and a queue request together while the controller is idle. The trigger must be issued and the queue request must be stored, not lost.

// File: rtl/evq_pkg.sv
package evq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} evq_state_e;

  // Busy window closes on done, or once elapsed+1 reaches limit (limit 0 acts as 1).
  function automatic logic window_over(input logic [31:0] elapsed,
                                       input logic [31:0] limit,
                                       input logic        fin);
    return fin || ((elapsed + 32'd1) >= limit);
  endfunction

  function automatic logic at_top(input logic [31:0] value, input int unsigned width);
    return value == ((32'd1 << width) - 32'd1);
  endfunction
endpackage

// File: rtl/evq_fifo.sv
module evq_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (count == '0);
  assign full     = (32'(count) == DEPTH);
  assign pop_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R5
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count) <= DEPTH);
endmodule

// File: rtl/evq_sat_cnt.sv
module evq_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] value
);
  logic top;
  assign top = evq_pkg::at_top(32'(value), W);

  always_ff @(posedge clk) begin
    if (!rst_n)          value <= '0;
    else if (inc && !top) value <= value + 1'b1;
  end

  // R3 R5
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    top |=> (value == $past(value)));
  // R3 R5
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !top) |=> (value == $past(value) + 1'b1));
endmodule

// File: rtl/evq_sequencer.sv
module evq_sequencer
  import evq_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int EVN_W = 16,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic [CMD_W-1:0] trig_cmd,
  input  logic             q_empty,
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [TO_W-1:0]  timeout,
  input  logic             done,
  input  logic             msg_ready,
  output logic             q_pop,
  output logic             trig_skip,
  output logic             msg_valid,
  output logic [CMD_W-1:0] msg_cmd,
  output logic             msg_trig,
  output logic [EVN_W-1:0] msg_evnum,
  output logic             busy
);
  evq_state_e      st;
  logic [TO_W-1:0] wait_cnt;
  logic            trig_take, accept, wait_end, idle;

  assign idle = (st == ST_IDLE);

  always_comb begin
    trig_take = trig_req && idle;
    trig_skip = trig_req && !idle;
    q_pop     = idle && !trig_req && !q_empty;
    accept    = (st == ST_SEND) && msg_ready;
    wait_end  = (st == ST_WAIT) && window_over(32'(wait_cnt), 32'(timeout), done);
  end

  assign msg_valid = (st == ST_SEND);
  assign busy      = !idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      msg_cmd   <= '0;
      msg_trig  <= 1'b0;
      msg_evnum <= '0;
      wait_cnt  <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (trig_take) begin
            msg_cmd  <= trig_cmd;
            msg_trig <= 1'b1;
            st       <= ST_SEND;
          end else if (q_pop) begin
            msg_cmd  <= q_cmd;
            msg_trig <= 1'b0;
            st       <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (accept) begin
            msg_evnum <= msg_evnum + 1'b1;
            wait_cnt  <= '0;
            st        <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_end) st <= ST_IDLE;
          else          wait_cnt <= wait_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_cmd) &&
                                   $stable(msg_trig) && $stable(msg_evnum)));
  // R7
  evnum_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (msg_evnum == $past(msg_evnum) + 1'b1));
  // R7
  evnum_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_ready) |=> $stable(msg_evnum));
  // R8
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready) |=> (busy && !msg_valid));
  // R3
  skip_no_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_skip && !msg_valid) |=> !msg_valid);
endmodule

// File: rtl/evq_ctrl.sv
module evq_ctrl #(
  parameter int CMD_W = 8,
  parameter int EVN_W = 16,
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  parameter int TO_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_req,
  input  logic [CMD_W-1:0] trig_cmd,
  input  logic             q_req,
  input  logic [CMD_W-1:0] q_cmd,
  input  logic [TO_W-1:0]  timeout,
  input  logic             done,
  input  logic             msg_ready,
  output logic             msg_valid,
  output logic [CMD_W-1:0] msg_cmd,
  output logic             msg_trig,
  output logic [EVN_W-1:0] msg_evnum,
  output logic             busy,
  output logic [CNT_W-1:0] skip_cnt,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam int NCNT = 2;

  logic             q_full, q_empty, q_push, q_drop, q_pop, trig_skip;
  logic [CMD_W-1:0] q_head;
  logic [NCNT-1:0]  cnt_ev;
  logic [CNT_W-1:0] cnt_val [NCNT];

  assign q_push = q_req && !q_full;
  assign q_drop = q_req && q_full;

  evq_fifo #(.DEPTH(DEPTH), .W(CMD_W)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(q_push), .push_data(q_cmd),
    .pop(q_pop), .pop_data(q_head),
    .empty(q_empty), .full(q_full)
  );

  evq_sequencer #(.CMD_W(CMD_W), .EVN_W(EVN_W), .TO_W(TO_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .trig_req(trig_req), .trig_cmd(trig_cmd),
    .q_empty(q_empty), .q_cmd(q_head),
    .timeout(timeout), .done(done), .msg_ready(msg_ready),
    .q_pop(q_pop), .trig_skip(trig_skip),
    .msg_valid(msg_valid), .msg_cmd(msg_cmd), .msg_trig(msg_trig),
    .msg_evnum(msg_evnum), .busy(busy)
  );

  assign cnt_ev = {q_drop, trig_skip};

  for (genvar gi = 0; gi < NCNT; gi++) begin : g_cnt
    evq_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(cnt_ev[gi]), .value(cnt_val[gi])
    );
  end

  assign skip_cnt = cnt_val[0];
  assign drop_cnt = cnt_val[1];

  // R6
  trig_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !busy) |=> (msg_valid && msg_trig && msg_cmd == $past(trig_cmd)));
  // R10
  same_cycle_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && !busy && q_req && !q_full) |=> !q_empty);
  // R3
  skip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_req && busy) |-> trig_skip);
endmodule

// File: tb/evq_ctrl_bench.sv
module evq_ctrl_bench;
  localparam int CMD_W = 8, EVN_W = 16, DEPTH = 16, CNT_W = 8, TO_W = 16;
  localparam int SAT = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0;
  logic trig_req = 0, q_req = 0, done = 0, msg_ready = 1;
  logic [CMD_W-1:0] trig_cmd = 0, q_cmd = 0;
  logic [TO_W-1:0]  timeout = 16'd1000;
  logic msg_valid, msg_trig, busy;
  logic [CMD_W-1:0] msg_cmd;
  logic [EVN_W-1:0] msg_evnum;
  logic [CNT_W-1:0] skip_cnt, drop_cnt;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  evq_ctrl #(.CMD_W(CMD_W), .EVN_W(EVN_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .TO_W(TO_W)) u_evq_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_req(trig_req), .trig_cmd(trig_cmd),
    .q_req(q_req), .q_cmd(q_cmd), .timeout(timeout), .done(done),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_cmd(msg_cmd),
    .msg_trig(msg_trig), .msg_evnum(msg_evnum), .busy(busy),
    .skip_cnt(skip_cnt), .drop_cnt(drop_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_trig(input logic [CMD_W-1:0] c);
    trig_req = 1; trig_cmd = c;
    @(negedge clk);
    trig_req = 0;
  endtask

  task automatic pulse_q(input logic [CMD_W-1:0] c);
    q_req = 1; q_cmd = c;
    @(negedge clk);
    q_req = 0;
  endtask

  task automatic drain();
    done = 1;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    done = 0;
  endtask

  // Wait for a queued message, check it, let it be accepted, close the window.
  task automatic serve_next(input logic [CMD_W-1:0] exp_cmd, input string req);
    int n = 0;
    while (!msg_valid && n < 50) begin @(negedge clk); n++; end
    chk(msg_valid && !msg_trig, req, "queued message valid/flag", {msg_valid, msg_trig}, 2'b10);
    chk(msg_cmd == exp_cmd, req, "queued command order", msg_cmd, exp_cmd);
    @(negedge clk);
    drain();
  endtask

  task automatic t_reset();
    chk(!msg_valid && !busy, "R1", "valid/busy after reset", {msg_valid, busy}, 0);
    chk(msg_evnum == 0, "R1", "event number after reset", msg_evnum, 0);
    chk(skip_cnt == 0 && drop_cnt == 0, "R1", "counters after reset", {skip_cnt, drop_cnt}, 0);
  endtask

  task automatic t_trigger_idle();
    logic [EVN_W-1:0] ev0 = msg_evnum;
    pulse_trig(8'h5A);
    chk(msg_valid && msg_trig, "R2", "trigger message next cycle", {msg_valid, msg_trig}, 2'b11);
    chk(msg_cmd == 8'h5A, "R2", "trigger command", msg_cmd, 8'h5A);
    chk(msg_evnum == ev0, "R7", "number presented", msg_evnum, ev0);
    @(negedge clk);
    chk(busy && !msg_valid, "R8", "busy after accept", {busy, msg_valid}, 2'b10);
    chk(msg_evnum == ev0 + 1, "R7", "number step on accept", msg_evnum, ev0 + 1);
    drain();
  endtask

  task automatic t_hold();
    logic [EVN_W-1:0] ev0 = msg_evnum;
    msg_ready = 0;
    pulse_trig(8'h36);
    repeat (4) @(negedge clk);
    chk(msg_valid && msg_cmd == 8'h36 && msg_evnum == ev0, "R7", "held message",
        msg_cmd, 8'h36);
    msg_ready = 1;
    @(negedge clk);
    chk(!msg_valid && msg_evnum == ev0 + 1, "R7", "release step", msg_evnum, ev0 + 1);
    drain();
  endtask

  task automatic t_done_window();
    timeout = 16'd1000;
    pulse_trig(8'h11);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk(busy && !msg_valid, "R8", "still busy without done", {busy, msg_valid}, 2'b10);
    done = 1;
    @(negedge clk);
    done = 0;
    chk(!busy, "R8", "idle after done", busy, 0);
  endtask

  task automatic t_timeout(input int t, input int exp);
    int n = 0;
    timeout = TO_W'(t);
    pulse_trig(8'h22);
    @(negedge clk);
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk(n == exp, "R9", "busy window length", n, exp);
    timeout = 16'd1000;
  endtask

  task automatic t_skip();
    logic [EVN_W-1:0] ev1;
    logic [CNT_W-1:0] s0;
    pulse_trig(8'h01);
    @(negedge clk);
    ev1 = msg_evnum; s0 = skip_cnt;
    pulse_trig(8'h02); pulse_trig(8'h03); pulse_trig(8'h04);
    chk(skip_cnt == s0 + 3, "R3", "skip count", skip_cnt, s0 + 3);
    chk(!msg_valid && msg_evnum == ev1, "R3", "no message from skipped", msg_evnum, ev1);
    drain();
    @(negedge clk);
    chk(!msg_valid && !busy, "R3", "skipped trigger not issued later", {msg_valid, busy}, 0);
  endtask

  task automatic t_fifo_order();
    pulse_trig(8'h09);
    @(negedge clk);
    pulse_q(8'h31); pulse_q(8'h32); pulse_q(8'h33);
    drain();
    serve_next(8'h31, "R4");
    serve_next(8'h32, "R4");
    serve_next(8'h33, "R4");
  endtask

  task automatic t_full_drop();
    logic [CNT_W-1:0] d0;
    pulse_trig(8'h0F);
    @(negedge clk);
    d0 = drop_cnt;
    for (int i = 0; i < DEPTH + 2; i++) pulse_q(CMD_W'(8'h40 + i));
    chk(drop_cnt == d0 + 2, "R5", "drops past 16", drop_cnt, d0 + 2);
    drain();
    for (int i = 0; i < DEPTH; i++) serve_next(CMD_W'(8'h40 + i), "R5");
    @(negedge clk);
    chk(!msg_valid && !busy, "R5", "dropped entries absent", {msg_valid, busy}, 0);
  endtask

  task automatic t_priority();
    logic [CNT_W-1:0] s0;
    pulse_trig(8'h0A);
    @(negedge clk);
    pulse_q(8'h99);
    done = 1;
    @(negedge clk);
    done = 0;
    s0 = skip_cnt;
    chk(!busy, "R6", "idle with queue loaded", busy, 0);
    pulse_trig(8'hEE);
    chk(msg_valid && msg_trig && msg_cmd == 8'hEE, "R6", "trigger wins", msg_cmd, 8'hEE);
    chk(skip_cnt == s0, "R6", "trigger not skipped", skip_cnt, s0);
    @(negedge clk);
    drain();
    serve_next(8'h99, "R6");
  endtask

  task automatic t_same_cycle();
    trig_req = 1; trig_cmd = 8'h03; q_req = 1; q_cmd = 8'h04;
    @(negedge clk);
    trig_req = 0; q_req = 0;
    chk(msg_valid && msg_trig && msg_cmd == 8'h03, "R10", "trigger issued", msg_cmd, 8'h03);
    @(negedge clk);
    drain();
    serve_next(8'h04, "R10");
  endtask

  task automatic t_saturation();
    msg_ready = 0;
    pulse_trig(8'h70);
    for (int i = 0; i < 300; i++) begin
      trig_req = 1; q_req = 1; trig_cmd = 8'h71; q_cmd = 8'h77;
      @(negedge clk);
    end
    trig_req = 0; q_req = 0;
    chk(skip_cnt == SAT, "R3", "skip saturates", skip_cnt, SAT);
    chk(drop_cnt == SAT, "R5", "drop saturates", drop_cnt, SAT);
    msg_ready = 1;
    @(negedge clk);
    drain();
    for (int i = 0; i < DEPTH; i++) serve_next(8'h77, "R4");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_trigger_idle();
    t_hold();
    t_done_window();
    t_timeout(7, 7);
    t_timeout(0, 1);
    t_skip();
    t_fifo_order();
    t_full_drop();
    t_priority();
    t_same_cycle();
    t_saturation();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule